// File: doc/BRIEF.md
# Constant-Coefficient Multiplier with Recoded Lookup and Pipelined Sum

This block multiplies an unsigned N-bit operand by a coefficient K that is fixed by a parameter when the design is elaborated. The operand is cut into overlapping four-bit windows spaced three bits apart. Each window addresses its own small table of signed multiples of K (zero, ±K, ±2K, ±3K, ±4K). The table is built at elaboration, so no shift, negation or 3K addition is done at run time. The selected partial products are shifted into place and reduced pairwise in an adder tree, with a register level after every adder level.

The operand and the product are both registered on one clock. A valid flag travels with the data, and a new operand may enter on every cycle. There is no flow control. Typical uses are filter taps, window scaling and fixed weights, where one multiplicand never changes.

Top module: `cmul_const`

## Requirements
- R1: For every operand accepted with in_valid high, out_p equals the exact 2N-bit product K·in_x.
- R2: With W = floor(N/3)+1 windows, the result appears 2 + ceil(log2(W)) rising edges after the edge that samples the operand. For N = 12 that is 5 edges.
- R3: A new operand is accepted on every cycle. Back-to-back valid operands each produce their own correct result on consecutive cycles.
- R4: out_valid is in_valid delayed by exactly the latency of R2. An operand presented with in_valid low never raises out_valid.
- R5: rst_n is active low and asynchronous. While it is low, out_valid and out_p are 0.
- R6: Window i is addressed by {x[3i+2], x[3i+1], x[3i], x[3i-1]}, with x[-1] = 0. It selects weight −4·a3 + 2·a2 + a1 + a0 times K. Addresses 0101 and 0110 select +3K, and 1001 and 1010 select −3K. Operands built from these patterns (for example 0x555, 0xAAA, 0x666, 0x999) give exact products.
- R7: Operand extremes give exact results: x = 0 gives 0, and x = all ones gives K·(2^N − 1). A coefficient of 0 gives 0 for every operand.
- R8: The operand is zero-extended above bit N−1 up to a multiple of three bits, so the top window is never negative. An operand with only its top bit set gives K·2^(N−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_x as a live operand this cycle |
| in_x | input | N | Unsigned operand |
| out_valid | output | 1 | Marks out_p as a live product |
| out_p | output | 2N | Product K·in_x |

## Verification
Every product and every valid flag is due a fixed number of edges after its operand is sampled: 2 + ceil(log2(W)), which is 5 for the default width. The bench drives an operand on a falling edge and logs it under that cycle's index. On each later falling edge it compares out_valid and out_p with the entry logged that many cycles earlier, so every comparison uses a settled value at a known distance. The checker module keeps its own delay line of the same length. It compares each rising edge against it, so a product that lands one cycle early or late fails even in back-to-back streams.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Signed weight picked by a four-bit window {a3,a2,a1,a0}
    function automatic int recode_weight(input logic [3:0] a);
        return -4 * int'(a[3]) + 2 * int'(a[2]) + int'(a[1]) + int'(a[0]);
    endfunction

    // Number of live operands at a given level of a pairwise reduction
    function automatic int level_count(input int n, input int lvl);
        int c;
        c = n;
        for (int s = 0; s < lvl; s++) c = (c + 1) / 2;
        return c;
    endfunction

endpackage

// File: rtl/cmul_ppgen.sv
module cmul_ppgen #(
    parameter int            N  = 12,
    parameter logic [N-1:0]  K  = '0,
    parameter int            AW = 30,
    parameter int            SH = 0
) (
    input  logic [3:0]    addr,
    output logic [AW-1:0] pp
);
    localparam int PW = N + 3;

    // Constant multiple of K for one window weight, two's complement in PW bits
    function automatic logic [PW-1:0] entry(input int w);
        logic [PW-1:0] base;
        logic [PW-1:0] mag;
        base = PW'(K);
        case ((w < 0) ? -w : w)
            0:       mag = '0;
            1:       mag = base;
            2:       mag = base << 1;
            3:       mag = (base << 1) + base;
            default: mag = base << 2;
        endcase
        return (w < 0) ? (~mag + 1'b1) : mag;
    endfunction

    logic [PW-1:0] tbl [16];

    for (genvar a = 0; a < 16; a++) begin : g_tbl
        assign tbl[a] = entry(cmul_pkg::recode_weight(4'(a)));
    end

    logic [PW-1:0] sel;
    assign sel = tbl[addr];
    assign pp  = {{(AW-PW){sel[PW-1]}}, sel} << SH;

endmodule

// File: rtl/cmul_tree.sv
module cmul_tree #(
    parameter int NIN = 5,
    parameter int AW  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [AW-1:0] in_pp [NIN],
    output logic          out_valid,
    output logic [AW-1:0] out_sum
);
    localparam int D = $clog2(NIN);

    logic [AW-1:0] lv [D+1][NIN];
    logic          vl [D+1];

    for (genvar j = 0; j < NIN; j++) begin : g_lv0
        assign lv[0][j] = in_pp[j];
    end
    assign vl[0] = in_valid;

    for (genvar l = 1; l <= D; l++) begin : g_lvl
        localparam int PREV = cmul_pkg::level_count(NIN, l - 1);
        localparam int CUR  = cmul_pkg::level_count(NIN, l);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vl[l] <= 1'b0;
            else        vl[l] <= vl[l-1];
        end

        for (genvar j = 0; j < NIN; j++) begin : g_node
            if (j < CUR && 2*j + 1 < PREV) begin : g_add
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) lv[l][j] <= '0;
                    else        lv[l][j] <= lv[l-1][2*j] + lv[l-1][2*j+1];
                end
            end else if (j < CUR) begin : g_pass
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) lv[l][j] <= '0;
                    else        lv[l][j] <= lv[l-1][2*j];
                end
            end else begin : g_idle
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) lv[l][j] <= '0;
                    else        lv[l][j] <= '0;
                end
            end
        end
    end

    assign out_sum   = lv[D][0];
    assign out_valid = vl[D];

endmodule

// File: rtl/cmul_const.sv
module cmul_const #(
    parameter int           N = 12,
    parameter logic [N-1:0] K = 12'hB5D
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   in_x,
    output logic           out_valid,
    output logic [2*N-1:0] out_p
);
    localparam int L  = (N / 3 + 1) * 3;   // padded operand length
    localparam int NW = L / 3;             // number of windows
    localparam int AW = L + N + 3;         // accumulation width

    logic          v_q;
    logic [N-1:0]  x_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            x_q <= '0;
        end else begin
            v_q <= in_valid;
            x_q <= in_x;
        end
    end

    // Bit 0 stands for x[-1]; the bits above the operand are zero
    logic [L:0] xp;
    assign xp = {{(L-N){1'b0}}, x_q, 1'b0};

    logic [AW-1:0] pp [NW];

    for (genvar i = 0; i < NW; i++) begin : g_win
        cmul_ppgen #(.N(N), .K(K), .AW(AW), .SH(3*i)) u_ppgen (
            .addr (xp[3*i+3 -: 4]),
            .pp   (pp[i])
        );
    end

    logic          sum_v;
    logic [AW-1:0] sum;

    cmul_tree #(.NIN(NW), .AW(AW)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (v_q),
        .in_pp     (pp),
        .out_valid (sum_v),
        .out_sum   (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_p     <= '0;
        end else begin
            out_valid <= sum_v;
            out_p     <= sum[2*N-1:0];
        end
    end

endmodule

// File: rtl/cmul_const_chk.sv
module cmul_const_chk #(
    parameter int           N = 12,
    parameter logic [N-1:0] K = '0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [N-1:0]   in_x,
    input logic           out_valid,
    input logic [2*N-1:0] out_p
);
    localparam int NW  = N / 3 + 1;
    localparam int LAT = 2 + $clog2(NW);

    logic           vd [LAT];
    logic [2*N-1:0] pd [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < LAT; j++) begin
                vd[j] <= 1'b0;
                pd[j] <= '0;
            end
        end else begin
            vd[0] <= in_valid;
            pd[0] <= (2*N)'(K) * (2*N)'(in_x);
            for (int j = 1; j < LAT; j++) begin
                vd[j] <= vd[j-1];
                pd[j] <= pd[j-1];
            end
        end
    end

    // R2, R4: out_valid follows in_valid at the fixed latency
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vd[LAT-1]);

    // R1, R3: each live product equals K times the operand sampled LAT edges back
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_p == pd[LAT-1]);

    // R5: reset leaves the outputs cleared
    a_r5_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_p == '0));

    // R7: a zero operand gives a zero product after the latency
    a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pd[LAT-1] == '0) |-> out_p == '0);

endmodule

bind cmul_const cmul_const_chk #(.N(N), .K(K)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .out_valid (out_valid),
    .out_p     (out_p)
);

// File: tb/cmul_const_bench.sv
module cmul_const_bench;
    localparam int N   = 12;
    localparam int NW  = N / 3 + 1;
    localparam int LAT = 2 + $clog2(NW);
    localparam int HD  = 4096;

    localparam logic [N-1:0] K0 = 12'hB5D;
    localparam logic [N-1:0] K1 = 12'h000;
    localparam logic [N-1:0] K2 = 12'h001;
    localparam logic [N-1:0] K3 = 12'hFFF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [N-1:0]   in_x = '0;
    logic           v [4];
    logic [2*N-1:0] p [4];

    always #2 clk = ~clk;

    cmul_const #(.N(N), .K(K0)) u_cmul_const (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(v[0]), .out_p(p[0]));
    cmul_const #(.N(N), .K(K1)) u_cmul_const_k0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(v[1]), .out_p(p[1]));
    cmul_const #(.N(N), .K(K2)) u_cmul_const_k1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(v[2]), .out_p(p[2]));
    cmul_const #(.N(N), .K(K3)) u_cmul_const_kmax (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(v[3]), .out_p(p[3]));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [N-1:0] hx [HD];
    logic         hv [HD];
    string        ht [HD];

    function automatic logic [N-1:0] kval(input int i);
        case (i)
            0:       return K0;
            1:       return K1;
            2:       return K2;
            default: return K3;
        endcase
    endfunction

    function automatic logic [2*N-1:0] expect_p(input int i, input logic [N-1:0] x);
        return (2*N)'(kval(i)) * (2*N)'(x);
    endfunction

    task automatic check_outputs();
        int k;
        k = cyc - LAT;
        for (int i = 0; i < 4; i++) begin
            if (!rst_n) begin
                checks++;
                if (v[i] !== 1'b0 || p[i] !== '0) begin
                    fails++;
                    $display("FAIL R5 dut%0d reset: valid=%0b p=%0h expected valid=0 p=0", i, v[i], p[i]);
                end
            end else begin
                logic ev;
                ev = (k >= 0) ? hv[k] : 1'b0;
                checks++;
                if (v[i] !== ev) begin
                    fails++;
                    $display("FAIL %s/R4 dut%0d cyc%0d: out_valid=%0b expected %0b",
                             (k >= 0) ? ht[k] : "R2", i, cyc, v[i], ev);
                end else if (ev) begin
                    checks++;
                    if (p[i] !== expect_p(i, hx[k])) begin
                        fails++;
                        $display("FAIL %s dut%0d x=%0h: out_p=%0h expected %0h",
                                 ht[k], i, hx[k], p[i], expect_p(i, hx[k]));
                    end
                end
            end
        end
    endtask

    task automatic step(input logic vld, input logic [N-1:0] x, input string tag);
        @(negedge clk);
        check_outputs();
        in_valid = vld;
        in_x     = x;
        hv[cyc]  = vld && rst_n;
        hx[cyc]  = x;
        ht[cyc]  = tag;
        cyc++;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1F2E3D);
        // R5: outputs held at zero during reset
        for (int r = 0; r < 4; r++) step(1'b0, '0, "R5");
        @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        hv[cyc] = 1'b0; hx[cyc] = '0; ht[cyc] = "R5"; cyc++;
        // Directed corners
        step(1'b1, 12'h000, "R7");
        step(1'b1, 12'hFFF, "R7");
        step(1'b1, 12'h800, "R8");
        step(1'b1, 12'h555, "R6");
        step(1'b1, 12'hAAA, "R6");
        step(1'b1, 12'h666, "R6");
        step(1'b1, 12'h999, "R6");
        step(1'b1, 12'h001, "R1");
        // R4: invalid operands must not raise out_valid
        step(1'b0, 12'h123, "R4");
        step(1'b0, 12'hFFF, "R4");
        // R1, R4: random operands with random gaps
        for (int c = 0; c < 300; c++)
            step(($urandom % 4) != 0, N'($urandom), "R1");
        // R3: back-to-back stream
        for (int c = 0; c < 100; c++)
            step(1'b1, N'($urandom), "R3");
        // Drain; R2: every result landed at the fixed latency
        for (int c = 0; c < LAT + 2; c++)
            step(1'b0, '0, "R2");
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule